// File: doc/BRIEF.md
# Fractional-Rate Second-Order CIC Interpolator

This block raises the sample rate of a complex (I/Q) baseband stream by a programmable ratio between 1 and 4096. The ratio can be fractional, in steps of 1/512. It takes its samples from an earlier integer interpolation stage and hands its output to a downstream tuner. Its filter is a second-order cascaded integrator-comb. Two differencing stages run at the input rate, and each input sample is zero-stuffed into two running-sum stages that run at the output rate.

An output step happens on each cycle where `out_en_i` is high and the data the step needs is present. A phase accumulator in units of 1/512 decides which steps also consume a new input sample. Every step adds 512 to the phase, and the phase wraps by the ratio. A step whose starting phase is below 512 takes an input through a ready/valid handshake. The filter grows in gain with the ratio. A programmable right shift with round-half-up and saturation brings the result back to the output width.

Top module: `rcic2_resampler`

## Requirements
- R1: While the synchronised reset is active, and on the first cycle after it is released, `out_valid_o` is 0, both output words are 0, and the phase is 0. The phase being 0 means `in_ready_o` equals `out_en_i`.
- R2: `in_ready_o` is high exactly when `out_en_i` is high and the phase is below 512. On every step the phase becomes phase+512, reduced by the ratio `rate_i` when that sum is at least the ratio.
- R3: A step happens only when `out_en_i` is high and either `in_ready_o` is low or `in_valid_i` is high. Without a step, the phase, the filter state and the output words are held.
- R4: `out_valid_o` is high in the cycle after each step, and only then. The output words then hold the result of that step.
- R5: With `rate_i` = 512 (ratio 1) and shift 0, every step consumes an input. Each output equals the input consumed one step earlier in the output stream, that is, the sample taken on that step.
- R6: The output is the response of two cascaded first differences, applied at the input rate, followed by two cascaded running sums at the output rate. The running sums receive the differenced sample on steps that take an input and zero on the other steps. All filter state starts at zero.
- R7: Scaling adds 2^(s-1) when the shift s is above 0, then shifts arithmetically right by s. Halves therefore round towards plus infinity.
- R8: A scaled value above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clamped to that limit.
- R9: A `rate_i` below 512 acts as 512, so every step takes an input.
- R10: The I and Q lanes use the same step and take decisions and the same shift. Each lane filters only its own input.
- R11: For an integer ratio L and a constant input x, the output settles to L·x after shift 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_i | input | RATE_IW+9 | Ratio, unsigned fixed point with 9 fractional bits |
| shift_i | input | SH_W | Right shift applied to the filter result |
| out_en_i | input | 1 | Requests one output step |
| in_valid_i | input | 1 | Input sample present |
| in_ready_o | output | 1 | The current step consumes an input |
| in_re_i | input | IN_W | Input I, two's complement |
| in_im_i | input | IN_W | Input Q, two's complement |
| out_valid_o | output | 1 | An output sample was produced on the previous step |
| out_re_o | output | OUT_W | Output I |
| out_im_o | output | OUT_W | Output Q |

## Verification
The bench builds the block with 12-bit input and output words and keeps the default ratio width. Gains of up to eight at ratios up to 8.0 therefore reach both saturation limits with ordinary full-scale data. Limiting the ratios to that range keeps each run short enough to pass through many phase wrap patterns, including non-integer ratios, stalls from missing input and idle enables. The outputs still reach the steady state needed to check DC gain and rounding.

// File: rtl/rcic_pkg.sv
package rcic_pkg;

  // Ratio fixed point: 9 fractional bits, unity = 512
  localparam int FRAC_W    = 9;
  localparam int UNITY     = 1 << FRAC_W;
  localparam int CIC_ORDER = 2;

  typedef struct packed {
    logic step;   // an output step happens this cycle
    logic take;   // that step consumes an input sample
  } step_t;

endpackage

// File: rtl/rcic_phase.sv
module rcic_phase
  import rcic_pkg::*;
#(
  parameter int RATE_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              ready_o,
  output step_t             ctl_o
);

  localparam logic [RATE_W:0]   UNIT_X = (RATE_W+1)'(UNITY);
  localparam logic [RATE_W-1:0] UNIT   = RATE_W'(UNITY);

  logic [RATE_W-1:0] ph_q;
  logic [RATE_W-1:0] ph_d;
  logic [RATE_W-1:0] rate_eff;
  logic [RATE_W:0]   sum;
  logic              need;

  // next-state logic
  always_comb begin
    rate_eff   = (rate_i < UNIT) ? UNIT : rate_i;
    need       = (ph_q < UNIT);
    ready_o    = en_i & need;
    ctl_o.step = en_i & (~need | valid_i);
    ctl_o.take = en_i & need & valid_i;
    sum        = {1'b0, ph_q} + UNIT_X;
    if (sum >= {1'b0, rate_eff}) begin
      ph_d = sum[RATE_W-1:0] - rate_eff;
    end else begin
      ph_d = sum[RATE_W-1:0];
    end
  end

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else if (ctl_o.step) begin
      ph_q <= ph_d;
    end
  end

endmodule

// File: rtl/rcic_scale.sv
module rcic_scale #(
  parameter int INT_W = 31,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic [INT_W-1:0] v_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [OUT_W-1:0] y_o
);

  localparam logic signed [INT_W:0] MAXV = (INT_W+1)'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [INT_W:0] MINV = ~MAXV;

  logic signed [INT_W:0] ext;
  logic signed [INT_W:0] half;
  logic signed [INT_W:0] rnd;
  logic signed [INT_W:0] shd;

  always_comb begin
    ext  = $signed({v_i[INT_W-1], v_i});
    half = $signed(((INT_W+1)'(1) << sh_i) >> 1);
    rnd  = ext + half;
    shd  = rnd >>> sh_i;
    if (shd > MAXV) begin
      y_o = MAXV[OUT_W-1:0];
    end else if (shd < MINV) begin
      y_o = MINV[OUT_W-1:0];
    end else begin
      y_o = shd[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/rcic_lane.sv
module rcic_lane #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int INT_W = 31,
  parameter int SH_W  = 5,
  parameter int ORDER = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             take_i,
  input  logic [IN_W-1:0]  x_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [OUT_W-1:0] y_o
);

  logic [INT_W-1:0] cmb [ORDER+1];
  logic [INT_W-1:0] itg [ORDER+1];
  logic [OUT_W-1:0] y_d;
  logic [OUT_W-1:0] y_q;

  assign cmb[0] = INT_W'($signed(x_i));
  // zero-stuffing: differenced sample only on steps that take an input
  assign itg[0] = take_i ? cmb[ORDER] : '0;

  // differencing stages, input rate
  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    logic [INT_W-1:0] dly_q;
    assign cmb[g+1] = cmb[g] - dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dly_q <= '0;
      end else if (take_i) begin
        dly_q <= cmb[g];
      end
    end
  end

  // running-sum stages, output rate, wraparound arithmetic
  for (genvar g = 0; g < ORDER; g++) begin : g_intg
    logic [INT_W-1:0] sum_q;
    assign itg[g+1] = sum_q + itg[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_q <= '0;
      end else if (step_i) begin
        sum_q <= itg[g+1];
      end
    end
  end

  rcic_scale #(
    .INT_W (INT_W),
    .OUT_W (OUT_W),
    .SH_W  (SH_W)
  ) u_scale (
    .v_i  (itg[ORDER]),
    .sh_i (shift_i),
    .y_o  (y_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q <= '0;
    end else if (step_i) begin
      y_q <= y_d;
    end
  end

  assign y_o = y_q;

endmodule

// File: rtl/rcic2_resampler.sv
module rcic2_resampler
  import rcic_pkg::*;
#(
  parameter  int IN_W    = 16,
  parameter  int OUT_W   = 16,
  parameter  int RATE_IW = 13,
  localparam int RATE_W  = RATE_IW + FRAC_W,
  localparam int INT_W   = IN_W + (CIC_ORDER - 1) * RATE_IW + CIC_ORDER,
  localparam int SH_W    = $clog2(INT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic              out_en_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IN_W-1:0]   in_re_i,
  input  logic [IN_W-1:0]   in_im_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_re_o,
  output logic [OUT_W-1:0]  out_im_o
);

  localparam int LANES = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n;
  step_t      ctl;
  logic       valid_q;
  logic [IN_W-1:0]  lane_x [LANES];
  logic [OUT_W-1:0] lane_y [LANES];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  rcic_phase #(
    .RATE_W (RATE_W)
  ) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .en_i    (out_en_i),
    .valid_i (in_valid_i),
    .rate_i  (rate_i),
    .ready_o (in_ready_o),
    .ctl_o   (ctl)
  );

  assign lane_x[0] = in_re_i;
  assign lane_x[1] = in_im_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rcic_lane #(
      .IN_W  (IN_W),
      .OUT_W (OUT_W),
      .INT_W (INT_W),
      .SH_W  (SH_W),
      .ORDER (CIC_ORDER)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .step_i  (ctl.step),
      .take_i  (ctl.take),
      .x_i     (lane_x[l]),
      .shift_i (shift_i),
      .y_o     (lane_y[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= ctl.step;
    end
  end

  assign out_valid_o = valid_q;
  assign out_re_o    = lane_y[0];
  assign out_im_o    = lane_y[1];

endmodule

// File: rtl/rcic2_resampler_chk.sv
module rcic2_resampler_chk
  import rcic_pkg::*;
#(
  parameter int RATE_W = 22,
  parameter int OUT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [RATE_W-1:0] rate_i,
  input logic              out_en_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [OUT_W-1:0]  out_re_o,
  input logic [OUT_W-1:0]  out_im_o
);

  // R2: a request for input only exists on an enabled cycle
  p_ready_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_ready_o |-> out_en_i);

  // R4: every step yields a valid output on the next cycle
  p_valid_after_step_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (out_en_i && (!in_ready_o || in_valid_i)) |=> out_valid_o);

  // R3: no step means no valid and held outputs
  p_hold_without_step_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(out_en_i && (!in_ready_o || in_valid_i))
      |=> (!out_valid_o && $stable(out_re_o) && $stable(out_im_o)));

  // R9: a ratio at or below unity takes an input on every enabled cycle
  p_low_rate_takes_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rate_i <= RATE_W'(UNITY) && out_en_i) |-> in_ready_o);

  // R3: an idle enable never requests data
  p_idle_no_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !out_en_i |-> !in_ready_o);

endmodule

bind rcic2_resampler rcic2_resampler_chk #(
  .RATE_W (RATE_W),
  .OUT_W  (OUT_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .rate_i      (rate_i),
  .out_en_i    (out_en_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_re_o    (out_re_o),
  .out_im_o    (out_im_o)
);

// File: tb/rcic2_resampler_tb_top.sv
`timescale 1ns/1ps
module rcic2_resampler_tb_top;

  localparam int IW  = 12;
  localparam int OW  = 12;
  localparam int RIW = 13;
  localparam int RW  = RIW + 9;
  localparam int SW  = 5;
  localparam longint OMAX = 2047;
  localparam longint OMIN = -2048;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [RW-1:0] rate;
  logic [SW-1:0] sh;
  logic          en, vld;
  logic [IW-1:0] xre, xim;
  logic          rdy, ov;
  logic [OW-1:0] yre, yim;

  rcic2_resampler #(
    .IN_W    (IW),
    .OUT_W   (OW),
    .RATE_IW (RIW)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rate_i      (rate),
    .shift_i     (sh),
    .out_en_i    (en),
    .in_valid_i  (vld),
    .in_ready_o  (rdy),
    .in_re_i     (xre),
    .in_im_i     (xim),
    .out_valid_o (ov),
    .out_re_o    (yre),
    .out_im_o    (yim)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  longint m_ph, m_rate, m_raw;
  longint st [2][4];   // per lane: x_prev, d1_prev, sum1, sum2
  bit     pend;
  longint ere, eim, pt_x;
  longint act_re, act_im;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint scale_ref(longint v, int s);
    longint r;
    r = (s == 0) ? v : ((v + (64'sd1 <<< (s - 1))) >>> s);
    if (r > OMAX) r = OMAX;
    if (r < OMIN) r = OMIN;
    return r;
  endfunction

  task automatic lane_ref(int l, bit take, longint x, output longint y);
    longint d1, d2, u;
    d1 = x - st[l][0];
    d2 = d1 - st[l][1];
    if (take) begin
      st[l][0] = x;
      st[l][1] = d1;
    end
    u = take ? d2 : 0;
    st[l][2] = st[l][2] + u;
    st[l][3] = st[l][3] + st[l][2];
    y = scale_ref(st[l][3], int'(sh));
  endtask

  task automatic do_reset(longint r, int s);
    @(negedge clk);
    rst_n = 1'b0; en = 0; vld = 0; xre = '0; xim = '0;
    rate = RW'(r); sh = SW'(s);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_raw  = r;
    m_rate = (r < 512) ? 512 : r;
    m_ph = 0; pend = 0;
    for (int l = 0; l < 2; l++)
      for (int k = 0; k < 4; k++) st[l][k] = 0;
    repeat (2) @(negedge clk);
    // R1: state right after the synchronised release
    chk(ov == 1'b0, "R1 out_valid after reset", ov, 0);
    chk(yre == '0, "R1 out_re after reset", longint'($signed(yre)), 0);
    chk(yim == '0, "R1 out_im after reset", longint'($signed(yim)), 0);
    en = 1'b1;
    #1;
    chk(rdy == 1'b1, "R1 in_ready follows enable at phase 0", rdy, 1);
    en = 1'b0;
  endtask

  task automatic cycle(bit e, bit v, longint dr, longint di, string tag);
    bit need, step;
    @(negedge clk);
    chk(ov == pend, "R3 R4 out_valid", ov, pend);
    if (pend) begin
      act_re = longint'($signed(yre));
      act_im = longint'($signed(yim));
      chk(act_re == ere, tag, act_re, ere);
      chk(act_im == eim, "R10 im lane", act_im, eim);
      if (m_rate == 512 && sh == 0)
        chk(act_re == pt_x, "R5 passthrough", act_re, pt_x);
    end
    en = e; vld = v; xre = IW'(dr); xim = IW'(di);
    #1;
    need = (m_ph < 512);
    chk(rdy == (e && need), (m_raw < 512) ? "R9 clamp ready" : "R2 in_ready", rdy, e && need);
    step = e && (!need || v);
    if (step) begin
      lane_ref(0, need, dr, ere);
      lane_ref(1, need, di, eim);
      pt_x = dr;
      m_ph = m_ph + 512;
      if (m_ph >= m_rate) m_ph = m_ph - m_rate;
      pend = 1;
    end else begin
      pend = 0;
    end
  endtask

  // mode 0: steady random, 1: constant dc, 2: random gaps
  task automatic run(longint r, int s, int n, int mode, longint dc, string tag);
    longint dr, di;
    bit e, v;
    do_reset(r, s);
    for (int i = 0; i < n; i++) begin
      e = 1; v = 1;
      dr = longint'($urandom_range(4095)) - 2048;
      di = longint'($urandom_range(4095)) - 2048;
      if (mode == 1) begin dr = dc; di = -dc; end
      if (mode == 2) begin
        e = ($urandom_range(3) != 0);
        v = ($urandom_range(1) != 0);
      end
      cycle(e, v, dr, di, tag);
    end
    cycle(0, 0, 0, 0, tag);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0; en = 0; vld = 0; rate = RW'(512); sh = '0; xre = '0; xim = '0;

    // R5: unity ratio passes data through
    run(512, 0, 60, 0, 0, "R5 R6 unity ratio");
    // R9: ratio below unity behaves as unity
    run(100, 0, 40, 0, 0, "R9 R6 clamped ratio");
    // R11: integer ratio 4, DC gain
    run(2048, 0, 40, 1, 100, "R6 dc ratio 4");
    chk(act_re == 400, "R11 dc gain re", act_re, 400);
    chk(act_im == -400, "R11 dc gain im", act_im, -400);
    // R7: rounding of halves upward
    run(1024, 2, 30, 1, 5, "R6 rounding run");
    chk(act_re == 3, "R7 round 2.5", act_re, 3);
    chk(act_im == -2, "R7 round -2.5", act_im, -2);
    // R8: saturation at both limits, ratio 8
    run(4096, 0, 60, 1, 2000, "R6 saturation run");
    chk(act_re == OMAX, "R8 saturate high", act_re, OMAX);
    chk(act_im == OMIN, "R8 saturate low", act_im, OMIN);
    // R3: stalls and idle enables at fractional ratio 2.5
    run(1280, 1, 300, 2, 0, "R3 R6 gaps");
    // R2: fractional ratio 1.5 and 3.25
    run(768, 1, 200, 0, 0, "R2 R6 ratio 1.5");
    run(1664, 2, 200, 2, 0, "R2 R6 ratio 3.25");
    // random ratios and shifts
    for (int k = 0; k < 12; k++) begin
      run(longint'($urandom_range(4096, 512)), int'($urandom_range(4)), 250,
          ($urandom_range(1) != 0) ? 2 : 0, 0, "R6 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule